// File: doc/BRIEF.md
# BCD Code Holder with Seven-Segment Decode

This block keeps a four-bit decimal digit code and turns it into active-high drive levels for the seven segments of a numeric display. A hold control decides whether the kept code follows the incoming digit or stays frozen. Two active-low overrides sit after the decoder. One lights every segment, so the display can be checked for dead segments. The other darkens the display, for example to dim it by pulsing. The lighting override wins when both are active. Neither override changes the kept code, so releasing an override shows the held digit again.

The latch is modelled synchronously. On each rising clock edge the code register loads the digit input when the hold control is low. The segment outputs are registered. A digit change therefore reaches the outputs two clocks later, and an override change reaches them one clock later. Codes above nine give a dark display.

Top module: `bcd_seg_hold`

## Requirements
- R1: While `lamp_chk_n` is 0, `seg` is 7'b1111111 one clock later, regardless of `blank_n`, `hold` and `digit`.
- R2: While `lamp_chk_n` is 1 and `blank_n` is 0, `seg` is 7'b0000000 one clock later, regardless of `hold` and `digit`.
- R3: On a rising clock edge with `hold` 0, the kept code loads `digit`. With no override active, `seg` shows that code two clocks after `digit` was applied.
- R4: While `hold` is 1, the kept code does not change, and changes on `digit` have no effect on `seg`.
- R5: With no override active, codes 10 to 15 give `seg` = 7'b0000000.
- R6: `seg` bit 6 is segment a and bit 0 is segment g. Codes 0 to 9 map to 7E,30,6D,79,33,5B,1F,70,7F,73 (hex).
- R7: The overrides do not change the kept code. After an override is released, the held digit reappears one clock later.
- R8: A synchronous active-high `rst` clears the kept code to 0 and `seg` to 0000000. After reset is released with `hold` 1 and no override, `seg` shows the pattern for 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| digit | input | 4 | Digit code; bit 0 is the least significant |
| hold | input | 1 | 0: the kept code follows `digit`; 1: it is frozen |
| blank_n | input | 1 | Active-low display blanking |
| lamp_chk_n | input | 1 | Active-low all-segments-on test |
| seg | output | 7 | Segment drive levels, {a,b,c,d,e,f,g} |

## Verification
The hardest case to reach is proving that an override left the frozen code untouched. The code cannot be seen while an override is active. The bench freezes a digit, then changes `digit` while the lamp test or blanking is active. It then releases the override with `hold` still high. The digit that appears at that point must be the frozen one and not the current input. Every one of the 16 codes is also decoded under all four override combinations and with both hold states.

// File: rtl/bcd_seg_pkg.sv
package bcd_seg_pkg;
   localparam int SEG_N  = 7;
   localparam int CODE_W = 4;
   typedef logic [SEG_N-1:0]  seg_t;
   typedef logic [CODE_W-1:0] code_t;

   localparam seg_t SEG_ALL  = '1;
   localparam seg_t SEG_NONE = '0;

   function automatic seg_t glyph(input code_t c);
      case (c)
         4'd0: glyph = 7'b1111110;
         4'd1: glyph = 7'b0110000;
         4'd2: glyph = 7'b1101101;
         4'd3: glyph = 7'b1111001;
         4'd4: glyph = 7'b0110011;
         4'd5: glyph = 7'b1011011;
         4'd6: glyph = 7'b0011111;
         4'd7: glyph = 7'b1110000;
         4'd8: glyph = 7'b1111111;
         4'd9: glyph = 7'b1110011;
         default: glyph = SEG_NONE;
      endcase
   endfunction
endpackage

// File: rtl/bcd_code_reg.sv
module bcd_code_reg
   import bcd_seg_pkg::*;
#(
   parameter int W = CODE_W
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         hold,
   input  logic [W-1:0] d_in,
   output logic [W-1:0] q
);
   initial assert (W >= 1) else $error("code width must be positive");

   always_ff @(posedge clk) begin
      if (rst)        q <= '0;
      else if (!hold) q <= d_in;
   end
endmodule

// File: rtl/bcd_seg_decode.sv
module bcd_seg_decode
   import bcd_seg_pkg::*;
#(
   parameter bit BLANK_ILLEGAL = 1'b1
) (
   input  code_t code,
   output seg_t  pattern
);
   localparam code_t MAX_DIGIT = 4'd9;

   generate
      if (BLANK_ILLEGAL) begin : g_blank
         assign pattern = (code > MAX_DIGIT) ? SEG_NONE : glyph(code);
      end else begin : g_raw
         assign pattern = glyph(code);
      end
   endgenerate
endmodule

// File: rtl/bcd_seg_override.sv
module bcd_seg_override
   import bcd_seg_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic blank_n,
   input  logic lamp_chk_n,
   input  seg_t pattern,
   output seg_t seg_q
);
   always_ff @(posedge clk) begin
      if (rst)              seg_q <= SEG_NONE;
      else if (!lamp_chk_n) seg_q <= SEG_ALL;
      else if (!blank_n)    seg_q <= SEG_NONE;
      else                  seg_q <= pattern;
   end
endmodule

// File: rtl/bcd_seg_hold.sv
module bcd_seg_hold
   import bcd_seg_pkg::*;
#(
   parameter bit BLANK_ILLEGAL = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [3:0] digit,
   input  logic       hold,
   input  logic       blank_n,
   input  logic       lamp_chk_n,
   output logic [6:0] seg
);
   code_t kept;
   seg_t  pat;

   bcd_code_reg #(.W(CODE_W)) u_code (
      .clk(clk), .rst(rst), .hold(hold), .d_in(digit), .q(kept));

   bcd_seg_decode #(.BLANK_ILLEGAL(BLANK_ILLEGAL)) u_dec (
      .code(kept), .pattern(pat));

   bcd_seg_override u_ovr (
      .clk(clk), .rst(rst), .blank_n(blank_n), .lamp_chk_n(lamp_chk_n),
      .pattern(pat), .seg_q(seg));
endmodule

// File: rtl/bcd_seg_hold_chk.sv
module bcd_seg_hold_chk (
   input logic       clk,
   input logic       rst,
   input logic [3:0] digit,
   input logic       hold,
   input logic       blank_n,
   input logic       lamp_chk_n,
   input logic [3:0] kept,
   input logic [6:0] seg
);
   // R1
   lamp_on_chk: assert property (@(posedge clk) disable iff (rst)
      !lamp_chk_n |=> (seg == 7'h7F));
   // R2
   blank_off_chk: assert property (@(posedge clk) disable iff (rst)
      (lamp_chk_n && !blank_n) |=> (seg == 7'h00));
   // R3
   track_load_chk: assert property (@(posedge clk) disable iff (rst)
      !hold |=> (kept == $past(digit)));
   // R4
   frozen_chk: assert property (@(posedge clk) disable iff (rst)
      hold |=> $stable(kept));
   // R5
   illegal_dark_chk: assert property (@(posedge clk) disable iff (rst)
      (lamp_chk_n && blank_n && kept > 4'd9) |=> (seg == 7'h00));
   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (kept == 4'd0 && seg == 7'h00));
endmodule

bind bcd_seg_hold bcd_seg_hold_chk u_chk (
   .clk(clk), .rst(rst), .digit(digit), .hold(hold), .blank_n(blank_n),
   .lamp_chk_n(lamp_chk_n), .kept(kept), .seg(seg));

// File: tb/bcd_seg_hold_bench.sv
module bcd_seg_hold_bench;
   logic clk = 0;
   logic rst = 1;
   logic [3:0] digit = 0;
   logic hold = 1, blank_n = 1, lamp_chk_n = 1;
   logic [6:0] seg;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   bcd_seg_hold u_bcd_seg_hold (.clk(clk), .rst(rst), .digit(digit), .hold(hold),
      .blank_n(blank_n), .lamp_chk_n(lamp_chk_n), .seg(seg));

   function automatic logic [6:0] model(input logic [3:0] c);
      logic [6:0] t[10] = '{7'h7E,7'h30,7'h6D,7'h79,7'h33,7'h5B,7'h1F,7'h70,7'h7F,7'h73};
      return (c > 9) ? 7'h00 : t[c];
   endfunction

   task automatic tick(input int n = 1);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [6:0] exp);
      checks++;
      if (seg !== exp) begin
         errors++;
         $display("FAIL %s: seg=%b expected=%b", req, seg, exp);
      end
   endtask

   task automatic t_reset();
      rst = 1; hold = 1; tick(2);
      check("R8 reset", 7'h00);
      rst = 0; tick(1);
      check("R8 after reset shows 0", model(0));
   endtask

   task automatic t_all_codes();
      for (int c = 0; c < 16; c++) begin
         hold = 0; digit = c[3:0]; tick(2);
         check(c > 9 ? "R5 illegal dark" : "R6 glyph", model(c[3:0]));
         check("R3 track", model(c[3:0]));
         for (int o = 0; o < 4; o++) begin
            lamp_chk_n = o[0]; blank_n = o[1]; hold = o[0] ^ o[1];
            tick(1);
            if (!lamp_chk_n) check("R1 lamp test", 7'h7F);
            else if (!blank_n) check("R2 blank", 7'h00);
            else check("R6 no override", model(c[3:0]));
         end
         lamp_chk_n = 1; blank_n = 1;
      end
   endtask

   task automatic t_hold();
      hold = 0; digit = 4'd3; tick(2);
      hold = 1;
      for (int c = 0; c < 16; c++) begin
         digit = c[3:0]; tick(1);
         check("R4 frozen", model(3));
      end
   endtask

   task automatic t_override_keeps();
      hold = 0; digit = 4'd6; tick(2);
      hold = 1; lamp_chk_n = 0; digit = 4'd2; tick(2);
      check("R1 lamp over held", 7'h7F);
      lamp_chk_n = 1; tick(1);
      check("R7 held after lamp test", model(6));
      blank_n = 0; lamp_chk_n = 0; digit = 4'd9; tick(1);
      check("R1 lamp beats blank", 7'h7F);
      lamp_chk_n = 1; tick(1);
      check("R2 blank", 7'h00);
      blank_n = 1; tick(1);
      check("R7 held after blank", model(6));
      hold = 0; tick(1);
      check("R3 old until load visible", model(6));
      tick(1);
      check("R3 new digit after two clocks", model(9));
   endtask

   initial begin
      t_reset();
      t_all_codes();
      t_hold();
      t_override_keeps();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #100000;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule